// File: doc/BRIEF.md
# Mask-and-Latch Interrupt Controller

This block collects up to 32 interrupt lines into a single request to a CPU. Each line has one bit in a pending register and one bit in an enable register. A line sets its pending bit in one of two ways. An edge-type line sets it on a rising edge. A level-type line either mirrors its input or latches it, depending on a build option. The request to the CPU is asserted whenever a pending bit is also enabled. A companion output gives the lowest-numbered enabled pending line, so a service routine can work through lines in ascending order.

Software reaches both registers through a single-cycle register port: a write strobe, a read strobe and a one-bit select. A line is acknowledged by writing the pending register. A build parameter selects the acknowledge polarity: either a 1 or a 0 in a bit position clears that bit. With the zero-clears polarity, software acknowledges with a read-modify-write that leaves every bit set except the target. The same build normally latches level lines, which must then be cleared explicitly.

Top module: `mlic_top`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the enable register, the pending register, `cpu_irq`, `irq_idx_vld` and `reg_rdata`.
- R2: `cpu_irq` is high exactly one cycle after some line has both its pending bit and its enable bit (1 = enabled) set. An enable bit of 0 keeps that line from raising `cpu_irq`.
- R3: An edge-type line (its bit in `LEVEL_LINES` is 0) sets its pending bit on the edge after a 0-to-1 change. The bit stays set after the line falls, until it is acknowledged.
- R4: With `ACK_ZERO`=0, a 1 in a bit position written to the pending register clears that bit. A 0 leaves that bit unchanged.
- R5: With `ACK_ZERO`=1, a 0 in a bit position written to the pending register clears that bit. A 1 leaves that bit unchanged.
- R6: If a set and an acknowledge of the same line fall in the same cycle, the set wins and the bit stays pending.
- R7: With `LATCH_LEVEL`=0, the pending bit of a level-type line equals that line's input one cycle earlier. Writes to that bit have no effect.
- R8: With `LATCH_LEVEL`=1, a high level-type line sets its pending bit, and the bit stays set after the line drops. An acknowledge clears it only while the line is low.
- R9: `irq_idx` gives the lowest-numbered line that is both pending and enabled. `irq_idx_vld` is high only when such a line exists. Both have the same one-cycle timing as `cpu_irq`.
- R10: With `reg_sel`=0, `reg_wr` replaces the enable register. With `reg_rd`, `reg_rdata` shows the selected register on the cycle after the strobe (`reg_sel`=0 selects enable, `reg_sel`=1 selects pending). Without `reg_rd`, `reg_rdata` holds its value.
- R11: Acknowledging a line that is not pending changes no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NLINES | Interrupt inputs, bit i is line i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = pending register |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, valid the cycle after `reg_rd` |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| irq_idx | output | IDXW | Lowest enabled pending line |
| irq_idx_vld | output | 1 | `irq_idx` is meaningful |

## Verification
The bench runs two instances side by side on shared stimulus, one per acknowledge polarity and level option, and aims at these corner cases:
- **Set and acknowledge in the same cycle.** A design that lets the clear win would drop an interrupt, and the pending read-back would miss the bit.
- **Acknowledge while a latched level line is still high.** A latching design that honoured the clear would lose a live request.
- **Level line falls in the mirroring build.** A mirroring design that latched instead would keep `cpu_irq` high after the source went away.
- **Wrong polarity and stray acknowledges.** A polarity error, or a clear of a non-pending bit, would show up as unexpected bits in the pending read-back.
- **Two enabled lines pending together.** A priority encoder that favoured the highest line would report the wrong index.

// File: rtl/mlic_pkg.sv
// Package: shared encodings for the mask-and-latch interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mlic_pkg;

    // Acknowledge polarity of a pending-register write.
    typedef enum logic {
        ACK_WR1 = 1'b0,
        ACK_WR0 = 1'b1
    } ack_pol_e;

    // Register selector on the register port.
    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/mlic_edge.sv
// Module: mlic_edge
// Turns raw interrupt lines into a per-line "set pending" vector.
// Edge-type lines produce a one-cycle set on a 0-to-1 change.
// Latched level lines produce a set while high.
// Mirrored level lines produce no set; the pending stage copies them.
// Assumes: lines are already synchronous to clk.
module mlic_edge #(
    parameter int                NLINES      = 32,
    parameter logic [NLINES-1:0] LEVEL_LINES = '0,
    parameter bit                LATCH_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines,
    output logic [NLINES-1:0] set_vec
);

    logic [NLINES-1:0] prev_q;

    // Remember last cycle's line values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // Per-line choice of set source, fixed at build time.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (!LEVEL_LINES[i]) begin : g_edge
            assign set_vec[i] = lines[i] & ~prev_q[i];
        end else if (LATCH_LEVEL) begin : g_lvl_latch
            assign set_vec[i] = lines[i];
        end else begin : g_lvl_mirror
            assign set_vec[i] = 1'b0;
        end
    end

endmodule

// File: rtl/mlic_pend.sv
// Module: mlic_pend
// Holds the pending register. Software acknowledges clear bits using
// the selected polarity, and a set in the same cycle wins over a clear.
// Mirrored level lines ignore writes and copy their line each cycle.
// Assumes: ack_we is a single-cycle strobe.
module mlic_pend
    import mlic_pkg::*;
#(
    parameter int                NLINES      = 32,
    parameter ack_pol_e          ACK_POL     = ACK_WR1,
    parameter logic [NLINES-1:0] MIRROR_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] set_vec,
    input  logic [NLINES-1:0] lines,
    input  logic              ack_we,
    input  logic [NLINES-1:0] ack_data,
    output logic [NLINES-1:0] pend_q
);

    logic [NLINES-1:0] clr_vec;

    // Decode the acknowledge write into a clear vector.
    always_comb begin
        if (!ack_we)                clr_vec = '0;
        else if (ACK_POL == ACK_WR0) clr_vec = ~ack_data;
        else                        clr_vec = ack_data;
    end

    // One pending flop per line; the variant is chosen by line type.
    for (genvar i = 0; i < NLINES; i++) begin : g_bit
        if (MIRROR_MASK[i]) begin : g_mirror
            // Copy the level input; writes have no effect.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else        pend_q[i] <= lines[i];
            end
        end else begin : g_latch
            // Clear by acknowledge, then set with priority.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else        pend_q[i] <= (pend_q[i] & ~clr_vec[i]) | set_vec[i];
            end
        end
    end

endmodule

// File: rtl/mlic_lowidx.sv
// Module: mlic_lowidx
// Combinational finder of the lowest set bit of a vector, with a flag.
// Assumes: NLINES >= 2.
module mlic_lowidx #(
    parameter int NLINES = 32,
    localparam int IDXW  = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    output logic [IDXW-1:0]   idx,
    output logic              any
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDXW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mlic_top.sv
// Module: mlic_top
// Mask-and-latch interrupt controller: an enable register, a pending
// register, a registered CPU request and a registered lowest-line index.
// The register port is single-cycle, and read data appears one cycle
// after the read strobe.
// Assumes: irq_lines are synchronous to clk; reset is synchronous, active low.
module mlic_top
    import mlic_pkg::*;
#(
    parameter int                NLINES      = 32,
    parameter bit                ACK_ZERO    = 1'b0,
    parameter bit                LATCH_LEVEL = 1'b0,
    parameter logic [NLINES-1:0] LEVEL_LINES = 32'hFFFF_0000,
    localparam int               IDXW        = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    output logic              cpu_irq,
    output logic [IDXW-1:0]   irq_idx,
    output logic              irq_idx_vld
);

    localparam ack_pol_e          ACK_POL     = ACK_ZERO ? ACK_WR0 : ACK_WR1;
    localparam logic [NLINES-1:0] MIRROR_MASK = LATCH_LEVEL ? '0 : LEVEL_LINES;

    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] status_q;
    logic [NLINES-1:0] set_vec;
    logic [NLINES-1:0] en_vec;
    logic [IDXW-1:0]   low_idx;
    logic              low_any;
    logic              ack_we;

    assign ack_we = reg_wr && (reg_sel_e'(reg_sel) == SEL_PENDING);
    assign en_vec = status_q & mask_q;

    mlic_edge #(
        .NLINES      (NLINES),
        .LEVEL_LINES (LEVEL_LINES),
        .LATCH_LEVEL (LATCH_LEVEL)
    ) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_lines),
        .set_vec (set_vec)
    );

    mlic_pend #(
        .NLINES      (NLINES),
        .ACK_POL     (ACK_POL),
        .MIRROR_MASK (MIRROR_MASK)
    ) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .lines    (irq_lines),
        .ack_we   (ack_we),
        .ack_data (reg_wdata),
        .pend_q   (status_q)
    );

    mlic_lowidx #(
        .NLINES (NLINES)
    ) lowidx_i (
        .vec (en_vec),
        .idx (low_idx),
        .any (low_any)
    );

    // Enable register: replaced on a write with the enable selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                                              mask_q <= '0;
        else if (reg_wr && (reg_sel_e'(reg_sel) == SEL_ENABLE)) mask_q <= reg_wdata;
    end

    // Register the request and the index so they reach the CPU from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq     <= 1'b0;
            irq_idx     <= '0;
            irq_idx_vld <= 1'b0;
        end else begin
            cpu_irq     <= |en_vec;
            irq_idx     <= low_idx;
            irq_idx_vld <= low_any;
        end
    end

    // Read data register: loaded on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= reg_sel ? status_q : mask_q;
    end

endmodule

// File: rtl/mlic_chk.sv
// Module: mlic_chk
// Property checker bound to mlic_top. It observes ports and the two
// registers, and keeps its own copy of last cycle's enabled pending set.
// Assumes: reset is held for at least one clock at start.
module mlic_chk #(
    parameter int                NLINES      = 32,
    parameter logic [NLINES-1:0] LEVEL_LINES = '0,
    localparam int               IDXW        = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] irq_lines,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] status_q,
    input logic              reg_rd,
    input logic [NLINES-1:0] reg_rdata,
    input logic              cpu_irq,
    input logic [IDXW-1:0]   irq_idx,
    input logic              irq_idx_vld
);

    logic [NLINES-1:0] en_past;
    logic [NLINES-1:0] below_idx;

    // Track the enabled pending set one cycle back.
    always_ff @(posedge clk) begin
        if (!rst_n) en_past <= '0;
        else        en_past <= status_q & mask_q;
    end

    assign below_idx = (NLINES'(1) << irq_idx) - NLINES'(1);

    // R2: nothing enabled means no request on the next cycle.
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !cpu_irq);

    // R9: the index flag and the request rise and fall together.
    a_r9_vld_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld == cpu_irq);

    // R9: the reported line was enabled and pending, with no lower line.
    a_r9_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_idx_vld) |->
            (en_past[irq_idx] && ((en_past & below_idx) == '0)));

    // R10: read data holds unless a read was strobed.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_rd)) |-> $stable(reg_rdata));

    // R3 and R6: a rising edge on an edge-type line is pending next cycle.
    for (genvar i = 0; i < NLINES; i++) begin : g_edge_chk
        if (!LEVEL_LINES[i]) begin : g_on
            a_r3_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $rose(irq_lines[i])) |=> status_q[i]);
        end
    end

endmodule

bind mlic_top mlic_chk #(
    .NLINES      (NLINES),
    .LEVEL_LINES (LEVEL_LINES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .mask_q      (mask_q),
    .status_q    (status_q),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata),
    .cpu_irq     (cpu_irq),
    .irq_idx     (irq_idx),
    .irq_idx_vld (irq_idx_vld)
);

// File: tb/mlic_top_tb_top.sv
// Bench: two controllers on shared stimulus.
// dut_i acknowledges with ones and mirrors level lines.
// dut_alt_i acknowledges with zeros and latches level lines.
// Register reads go through a scoreboard queue; other outputs are
// checked directly at the falling edge.
module mlic_top_tb_top;

    localparam int NL = 32;

    typedef struct {
        logic [NL-1:0] exp_s;
        logic [NL-1:0] exp_a;
        string         tag;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic          sel = 1'b0;
    logic [NL-1:0] wd_s = '0;
    logic [NL-1:0] wd_a = '0;
    logic [NL-1:0] rdat_s, rdat_a;
    logic          irq_s, irq_a, vld_s, vld_a;
    logic [4:0]    idx_s, idx_a;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    rd_item_t sb_q[$];

    always #4 clk = ~clk;

    mlic_top #(.ACK_ZERO(1'b0), .LATCH_LEVEL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr(wr), .reg_rd(rd),
        .reg_sel(sel), .reg_wdata(wd_s), .reg_rdata(rdat_s), .cpu_irq(irq_s),
        .irq_idx(idx_s), .irq_idx_vld(vld_s));

    mlic_top #(.ACK_ZERO(1'b1), .LATCH_LEVEL(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr(wr), .reg_rd(rd),
        .reg_sel(sel), .reg_wdata(wd_a), .reg_rdata(rdat_a), .cpu_irq(irq_a),
        .irq_idx(idx_a), .irq_idx_vld(vld_a));

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic s, input logic [NL-1:0] ds, input logic [NL-1:0] da);
        wr = 1'b1; sel = s; wd_s = ds; wd_a = da;
        cyc();
        wr = 1'b0;
    endtask

    // Driver: push the expected read data, then strobe the read.
    task automatic rd_reg(input logic s, input logic [NL-1:0] es, input logic [NL-1:0] ea,
                          input string tag);
        rd_item_t it;
        it.exp_s = es; it.exp_a = ea; it.tag = tag;
        sb_q.push_back(it);
        rd = 1'b1; sel = s;
        cyc();
        rd = 1'b0;
    endtask

    // Monitor: after each read edge, compare read data with the queue head.
    always @(posedge clk) begin
        if (rd && rst_n) begin
            rd_item_t it;
            #2;
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s: actual read with empty queue expected none", "R10");
            end else begin
                it = sb_q.pop_front();
                chk({it.tag, " std"}, rdat_s, it.exp_s);
                chk({it.tag, " alt"}, rdat_a, it.exp_a);
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1 irq std", NL'(irq_s), '0);
        chk("R1 irq alt", NL'(irq_a), '0);
        chk("R1 vld", NL'({vld_s, vld_a}), '0);
        chk("R1 rdata", rdat_s | rdat_a, '0);
        rd_reg(1'b0, '0, '0, "R1 enable");
        rd_reg(1'b1, '0, '0, "R1 pending");

        // R10: enable lines 1, 2, 16, 17
        wr_reg(1'b0, 32'h0003_0006, 32'h0003_0006);
        rd_reg(1'b0, 32'h0003_0006, 32'h0003_0006, "R10 enable");

        // R2 and R3: edge on masked line 0 latches without a request
        lines = 32'h1; cyc(); lines = '0; cyc(); cyc();
        chk("R2 masked std", NL'(irq_s), '0);
        chk("R2 masked alt", NL'(irq_a), '0);
        rd_reg(1'b1, 32'h1, 32'h1, "R3 line0");

        // R3, R2 and R9: pulse line 2, then line 1
        lines = 32'h4; cyc(); lines = '0; cyc();
        chk("R2 irq std", NL'(irq_s), 1);
        chk("R2 irq alt", NL'(irq_a), 1);
        chk("R9 idx2", NL'(idx_s), 2);
        lines = 32'h2; cyc(); lines = '0; cyc();
        chk("R9 lowest std", NL'(idx_s), 1);
        chk("R9 lowest alt", NL'(idx_a), 1);
        chk("R9 vld", NL'({vld_s, vld_a}), 3);
        rd_reg(1'b1, 32'h7, 32'h7, "R3 held");

        // R4 and R5: acknowledge line 1 with each polarity
        wr_reg(1'b1, 32'h2, ~32'h2);
        cyc();
        chk("R9 after ack", NL'(idx_s), 2);
        rd_reg(1'b1, 32'h5, 32'h5, "R4/R5 ack");
        wr_reg(1'b1, '0, '1);
        rd_reg(1'b1, 32'h5, 32'h5, "R4/R5 no-change");

        // R11: acknowledge line 5, which is not pending
        wr_reg(1'b1, 32'h20, ~32'h20);
        rd_reg(1'b1, 32'h5, 32'h5, "R11 not pending");

        // R6: edge on line 3 in the same cycle as its acknowledge
        lines = 32'h8;
        wr_reg(1'b1, 32'h8, ~32'h8);
        lines = '0;
        rd_reg(1'b1, 32'hD, 32'hD, "R6 set wins");

        // Clear every edge line
        wr_reg(1'b1, 32'hF, ~32'hF);
        cyc();
        chk("R2 cleared std", NL'(irq_s), '0);
        chk("R2 cleared alt", NL'(vld_a), '0);

        // R7 and R8: level line 16
        lines = 32'h0001_0000; cyc(); cyc();
        chk("R7 irq std", NL'(irq_s), 1);
        chk("R8 irq alt", NL'(irq_a), 1);
        chk("R9 idx16", NL'(idx_a), 16);
        wr_reg(1'b1, 32'h0001_0000, ~32'h0001_0000);
        rd_reg(1'b1, 32'h0001_0000, 32'h0001_0000, "R7/R8 ack while high");
        lines = '0; cyc();
        rd_reg(1'b1, '0, 32'h0001_0000, "R7/R8 after drop");
        chk("R7 irq dropped", NL'(irq_s), '0);
        chk("R8 irq held", NL'(irq_a), 1);
        wr_reg(1'b1, '0, ~32'h0001_0000);
        rd_reg(1'b1, '0, '0, "R8 cleared");

        // R2: pending line 1 with all enables removed
        lines = 32'h2; cyc(); lines = '0;
        wr_reg(1'b0, '0, '0);
        cyc();
        chk("R2 disabled std", NL'(irq_s), '0);
        chk("R2 disabled alt", NL'(irq_a), '0);
        rd_reg(1'b0, '0, '0, "R10 enable cleared");
        cyc(); cyc();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule